// File: doc/BRIEF.md
# Interrupt Pin Level Router

This block takes a set of external interrupt pins and steers each one onto a level in a small processor interrupt-number space. Every pin has a programmable level field. The fields are packed four to a 16-bit select register. A field of zero leaves its pin disconnected. All fields are written and read back over a simple synchronous register bus.

The routed pins are level-sensitive. A level counts as pending for as long as any pin steered to it is high. Pins that share a level are ORed together. Software masks levels through two write ports. Ones written to one port mask the matching levels, and ones written to the other port unmask them.

The block drives a registered output: the number of the highest pending, unmasked level, or zero when no such level exists.

Top module: `irq_pin_router`

## Requirements
- R1: After synchronous reset every select field is 0 and every mask bit is 1 (all levels masked). `irq_level` is 0 and `rdata` is 0.
- R2: Pin p's 4-bit field sits in select register p/4 at bits [4*(p%4)+3 : 4*(p%4)]. Register 0 is at address 0 and register 1 is at address 1. Reading address 0 or 1 returns that register. A pin routed to an unmasked level L between 1 and 14 makes `irq_level` equal L when it is the only high pin.
- R3: A pin whose field is 0 never causes a nonzero `irq_level`.
- R4: In a select write, a nibble holding 15 is ignored and that field keeps its previous value. The other nibbles of the same write still take effect, so no field ever holds 15.
- R5: Writing address 2 sets the mask bits where `wdata` has ones, and leaves the other bits alone. Bit n masks level n, and a masked level never appears on `irq_level`.
- R6: Writing address 3 clears the mask bits where `wdata` has ones, and leaves the other bits alone. A read of address 2 or 3 returns the mask.
- R7: `irq_level` follows the pins. It is nonzero while a routed pin on an unmasked level is high, and it returns to 0 after every such pin drops.
- R8: When several unmasked levels are pending, `irq_level` shows the highest level number.
- R9: Pins routed to the same level are ORed, so the level stays pending while any one of them is high.
- R10: `irq_level` is registered. A change on the pins or a register write at one clock edge shows on `irq_level` after the following edge and not before. `rdata` updates on the edge that samples `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pins | input | 8 | External interrupt pins, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 select low, 1 select high, 2 mask set, 3 mask clear |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq_level | output | 4 | Highest pending unmasked level, 0 if none |

## Verification
The bench builds the block with its default parameters: eight pins, 4-bit levels and 16-bit registers. That configuration is small enough to sweep every field value, 0 through 15, on every pin, reading each register back and checking the output each time. With all pins high, the bench walks the mask one level at a time to expose the priority order. It also checks shared-level ORing, mixed writes that contain a 15 nibble, and the one-cycle output latency.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // number of select registers needed for a pin count and field geometry
  function automatic int unsigned sel_reg_count(int unsigned pins, int unsigned lvl_w,
                                                int unsigned data_w);
    return (pins * lvl_w + data_w - 1) / data_w;
  endfunction

  // all-ones field value is reserved and never stored
  function automatic int unsigned reserved_level(int unsigned lvl_w);
    return (1 << lvl_w) - 1;
  endfunction
endpackage

// File: rtl/irq_sel_regs.sv
module irq_sel_regs #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned LVL_W    = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [NUM_PINS*LVL_W-1:0] sel_flat
);
  localparam int unsigned FPR = DATA_W / LVL_W;
  localparam logic [LVL_W-1:0] RSV = LVL_W'(irq_router_pkg::reserved_level(LVL_W));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_field
    localparam int unsigned REG = p / FPR;
    localparam int unsigned FLD = p % FPR;
    logic [LVL_W-1:0] fld_q;
    logic [LVL_W-1:0] nib;
    assign nib = wdata[FLD*LVL_W +: LVL_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        fld_q <= '0;
      end else if (wr_en && addr == ADDR_W'(REG) && nib != RSV) begin
        fld_q <= nib;
      end
    end

    assign sel_flat[p*LVL_W +: LVL_W] = fld_q;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned MASK_W   = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned SET_ADDR = 2,
  parameter int unsigned CLR_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [MASK_W-1:0] mask_q
);
  logic [MASK_W-1:0] wbits;
  assign wbits = wdata[MASK_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (wr_en && addr == ADDR_W'(SET_ADDR)) begin
      mask_q <= mask_q | wbits;
    end else if (wr_en && addr == ADDR_W'(CLR_ADDR)) begin
      mask_q <= mask_q & ~wbits;
    end
  end
endmodule

// File: rtl/irq_level_collect.sv
module irq_level_collect #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned LVL_W    = 4
) (
  input  logic [NUM_PINS-1:0]       pins,
  input  logic [NUM_PINS*LVL_W-1:0] sel_flat,
  output logic [(1<<LVL_W)-1:0]     pend
);
  localparam int unsigned NLVL = 1 << LVL_W;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    if (l == 0 || l == NLVL - 1) begin : g_none
      assign pend[l] = 1'b0;
    end else begin : g_or
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
          if (pins[p] && sel_flat[p*LVL_W +: LVL_W] == LVL_W'(l)) hit = 1'b1;
        end
      end
      assign pend[l] = hit;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned LVL_W = 4
) (
  input  logic [(1<<LVL_W)-1:0] req,
  output logic [LVL_W-1:0]      lvl
);
  always_comb begin
    lvl = '0;
    for (int i = 1; i < (1 << LVL_W); i++) begin
      if (req[i]) lvl = LVL_W'(i);
    end
  end
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned LVL_W    = 4,
  parameter int unsigned DATA_W   = 16,
  localparam int unsigned NUM_SEL = irq_router_pkg::sel_reg_count(NUM_PINS, LVL_W, DATA_W),
  localparam int unsigned ADDR_W  = $clog2(NUM_SEL + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_pins,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [LVL_W-1:0]    irq_level
);
  localparam int unsigned MASK_W = 1 << LVL_W;
  localparam int unsigned SEL_BITS = NUM_SEL * DATA_W;

  logic [NUM_PINS*LVL_W-1:0] sel_flat;
  logic [SEL_BITS-1:0]       sel_padded;
  logic [MASK_W-1:0]         mask_q;
  logic [MASK_W-1:0]         pend;
  logic [LVL_W-1:0]          top_lvl;
  logic [DATA_W-1:0]         rd_word;

  irq_sel_regs #(.NUM_PINS(NUM_PINS), .LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .sel_flat(sel_flat)
  );

  irq_mask_reg #(.MASK_W(MASK_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                 .SET_ADDR(NUM_SEL), .CLR_ADDR(NUM_SEL + 1)) u_mask (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .mask_q(mask_q)
  );

  irq_level_collect #(.NUM_PINS(NUM_PINS), .LVL_W(LVL_W)) u_collect (
    .pins(irq_pins), .sel_flat(sel_flat), .pend(pend)
  );

  irq_prio_enc #(.LVL_W(LVL_W)) u_prio (
    .req(pend & ~mask_q), .lvl(top_lvl)
  );

  assign sel_padded = SEL_BITS'(sel_flat);

  always_comb begin
    if (addr < ADDR_W'(NUM_SEL)) rd_word = sel_padded[DATA_W*addr +: DATA_W];
    else                         rd_word = DATA_W'(mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= '0;
      rdata     <= '0;
    end else begin
      irq_level <= top_lvl;
      if (rd_en) rdata <= rd_word;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned LVL_W    = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned NUM_SEL  = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_PINS-1:0]       pins,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         addr,
  input logic [DATA_W-1:0]         wdata,
  input logic [(1<<LVL_W)-1:0]     mask,
  input logic [NUM_PINS*LVL_W-1:0] sel,
  input logic [LVL_W-1:0]          irq_level
);
  localparam int unsigned MASK_W = 1 << LVL_W;
  logic [MASK_W-1:0] mask_d;

  always_ff @(posedge clk) begin
    if (rst) mask_d <= '1;
    else     mask_d <= mask;
  end

  // R5: a level shown on the output was unmasked when it was computed
  p_masked_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_level != '0) |-> !mask_d[irq_level]);

  // R5: mask-set write leaves the written ones set
  p_set_masks_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(NUM_SEL)) |=>
      ((mask & $past(wdata[MASK_W-1:0])) == $past(wdata[MASK_W-1:0])));

  // R6: mask-clear write leaves the written ones clear
  p_clr_unmasks_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(NUM_SEL + 1)) |=> ((mask & $past(wdata[MASK_W-1:0])) == '0));

  // R7: with all pins low the output falls to zero
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (pins == '0) |=> (irq_level == '0));

  // R4: reserved level never appears on the output
  p_no_reserved_out_r4: assert property (@(posedge clk) disable iff (rst)
    irq_level != '1);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_fld
    // R4: no stored field holds the reserved value
    p_field_valid_r4: assert property (@(posedge clk) disable iff (rst)
      sel[p*LVL_W +: LVL_W] != '1);
  end
endmodule

bind irq_pin_router irq_router_chk #(
  .NUM_PINS(NUM_PINS), .LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SEL(NUM_SEL)
) u_chk (
  .clk(clk), .rst(rst), .pins(irq_pins), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .mask(mask_q), .sel(sel_flat), .irq_level(irq_level)
);

// File: tb/tb_irq_pin_router.sv
module tb_irq_pin_router;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  irq_pins;
  logic        wr_en, rd_en;
  logic [1:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [3:0]  irq_level;

  int total = 0;
  int bad = 0;

  logic [3:0]  sel_m [8];
  logic [15:0] mask_m;

  always #5 clk = ~clk;

  irq_pin_router dut (
    .clk(clk), .rst(rst), .irq_pins(irq_pins), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_level(irq_level)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expect_lvl();
    logic [3:0] best = 4'd0;
    for (int l = 1; l < 15; l++)
      if (!mask_m[l])
        for (int p = 0; p < 8; p++)
          if (irq_pins[p] && sel_m[p] == 4'(l)) best = 4'(l);
    return best;
  endfunction

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 2) begin
      for (int f = 0; f < 4; f++)
        if (d[f*4 +: 4] != 4'hF) sel_m[a*4 + f] = d[f*4 +: 4];
    end else if (a == 2) mask_m = mask_m | d;
    else mask_m = mask_m & ~d;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    #1;
    check(tag, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_pins(logic [7:0] v);
    @(negedge clk);
    irq_pins = v;
  endtask

  task automatic chk_lvl(string tag);
    @(posedge clk);
    #1;
    check(tag, irq_level, expect_lvl());
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] prev;
    logic [15:0] w;
    string tg;
    rst = 1'b1; irq_pins = '0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    for (int p = 0; p < 8; p++) sel_m[p] = 4'd0;
    mask_m = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq_level after reset", irq_level, 0);
    check("R1 rdata after reset", rdata, 0);
    @(negedge clk);
    rst = 1'b0;
    rd(2'd0, 16'h0000, "R1 select low reset");
    rd(2'd1, 16'h0000, "R1 select high reset");
    rd(2'd2, 16'hFFFF, "R1 mask reset");
    set_pins(8'hFF);
    chk_lvl("R1 masked and unrouted gives zero");

    // R6: unmask all
    wr(2'd3, 16'hFFFF);
    rd(2'd3, 16'h0000, "R6 mask after clear-all");

    // R2 R3 R4: exhaustive sweep of every field value on every pin
    for (int p = 0; p < 8; p++) begin
      for (int v = 0; v < 16; v++) begin
        w = 16'(v) << (4 * (p % 4));
        wr(2'(p / 4), w);
        set_pins(8'(1 << p));
        if (v == 0) tg = "R3 unrouted pin";
        else if (v == 15) tg = "R4 reserved write ignored";
        else tg = "R2 single pin level";
        chk_lvl(tg);
        w = 16'd0;
        for (int f = 0; f < 4; f++) w[f*4 +: 4] = sel_m[(p / 4) * 4 + f];
        rd(2'(p / 4), w, "R2 select readback");
      end
    end

    // R4: mixed write with one reserved nibble
    wr(2'd0, 16'h2222);
    wr(2'd0, 16'hF3A1);
    rd(2'd0, 16'h23A1, "R4 mixed write keeps reserved nibble field");

    // R9: shared level
    wr(2'd0, 16'h0009);
    wr(2'd1, 16'h0090);
    set_pins(8'h01); chk_lvl("R9 shared level pin0");
    set_pins(8'h20); chk_lvl("R9 shared level pin5");
    set_pins(8'h21); chk_lvl("R9 shared level both");
    set_pins(8'h00); chk_lvl("R7 deassert returns zero");

    // R8 R5: all pins high on levels 1..8, walk the mask down
    wr(2'd0, 16'h4321);
    wr(2'd1, 16'h8765);
    set_pins(8'hFF);
    chk_lvl("R8 highest of eight");
    for (int l = 8; l >= 1; l--) begin
      wr(2'd2, 16'(1 << l));
      chk_lvl("R5 mask set walks priority");
    end
    rd(2'd2, 16'h01FE, "R5 mask readback");
    wr(2'd3, 16'h0020);
    chk_lvl("R6 clear one level");
    check("R6 clear one level value", irq_level, 5);

    // R10: output changes one edge after the pin change, not before
    wr(2'd3, 16'hFFFF);
    set_pins(8'h00);
    chk_lvl("R7 all low");
    @(negedge clk);
    prev = irq_level;
    irq_pins = 8'h40;
    #1;
    check("R10 no change before edge", irq_level, prev);
    @(posedge clk);
    #1;
    check("R10 change after edge", irq_level, 7);
    // select write: visible after the following edge
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 16'h0E00;
    @(posedge clk);
    #1;
    check("R10 still old level at write edge", irq_level, 7);
    @(negedge clk);
    wr_en = 1'b0;
    sel_m[6] = 4'hE;
    @(posedge clk);
    #1;
    check("R10 new level one edge later", irq_level, 14);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule